// File: doc/BRIEF.md
# Set-Associative Tag Lookup with Age-Counter Replacement

This block is the lookup stage of one cache bank. Each cycle it may receive one active request carrying a set index, a tag, a write flag, a mask of the requesters to answer and a replay flag. It searches the ways of the addressed set, ages the ways, picks a victim and decides, without a clock of delay, what happens next. The request can be answered at once, forwarded to memory as a write, cause a dirty victim to be written back, or go out as a miss that the miss-tracking logic will allocate and fill. Tag, valid, dirty and age state for every set and way lives here. Data arrays do not.

A separate fill input installs a line once memory returns it. It marks the recorded way of the recorded set valid and loads its tag. The WRITE_THROUGH parameter selects one of two write policies. The first is write-through with no allocation on a write miss. The second is write-back with dirty-victim eviction. Outputs are combinational from the current request and the stored state. State changes at the next rising clock edge.

Top module: `tag_lookup_lru`

## Requirements
- R1: A request with the replay flag set does no tag search and changes no state. It raises rsp_valid with rsp_who equal to its requester mask, and raises no memory write, write-back or miss.
- R2: On a lookup that is not a replay, every valid way whose tag matches has its age cleared to 0. Every other valid way has its age raised by one, saturating at 2^AGE_W-1. Invalid ways keep their age.
- R3: The victim (miss_way) is the lowest-numbered invalid way of the set if one exists. Otherwise it is the valid way with the largest age after the R2 update, with the lowest index winning ties.
- R4: In write-through mode a write hit raises mem_wr_valid with the request's line address and also responds.
- R5: In write-back mode a write hit sets the dirty bit of the matching way and raises no memory write.
- R6: Every hit (valid way with matching tag) raises rsp_valid with rsp_who equal to the request's requester mask, and raises no miss. rsp_who is zero whenever rsp_valid is low.
- R7: In write-back mode, a miss in a set with no invalid way raises wb_valid when the victim is dirty. wb_addr is built from the victim's stored tag and the request's set.
- R8: In write-through mode a write miss raises mem_wr_valid and rsp_valid in the same cycle. It raises no miss, and so no line is allocated.
- R9: Every other miss raises miss_valid with miss_way set to the victim, miss_write set to the write flag, and miss_addr set to the request's line address. Every line address (miss_addr, mem_wr_addr, wb_addr) is {tag, set, BANK_ID}, with the tag in the most significant bits and the bank id in the least significant bits.
- R10: A fill marks fill_way of fill_set valid, loads fill_tag, and clears that way's dirty bit and age. When a fill and a lookup touch the same way in the same cycle, the fill's values win.
- R11: After reset every way of every set is invalid, clean and at age 0, so the first lookup of any set misses with victim way 0 and no write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | An active request is present |
| req_replay | input | 1 | Request is a replay from miss tracking |
| req_write | input | 1 | Request is a write |
| req_set | input | SET_W | Set index |
| req_tag | input | TAG_W | Tag to compare |
| req_who | input | REQ_N | Mask of requesters to answer |
| fill_valid | input | 1 | Install a returned line |
| fill_set | input | SET_W | Set of the line being installed |
| fill_way | input | WAY_W | Way recorded at miss time |
| fill_tag | input | TAG_W | Tag of the line being installed |
| rsp_valid | output | 1 | Respond to the requesters this cycle |
| rsp_who | output | REQ_N | Requesters to answer |
| mem_wr_valid | output | 1 | Forward a write to memory |
| mem_wr_addr | output | ADDR_W | Line address of the forwarded write |
| wb_valid | output | 1 | Write back the dirty victim |
| wb_addr | output | ADDR_W | Line address of the victim |
| miss_valid | output | 1 | Allocate a miss entry and request a fill |
| miss_write | output | 1 | The missing request is a write |
| miss_way | output | WAY_W | Victim way to record with the miss |
| miss_addr | output | ADDR_W | Line address to fetch |

## Verification
The bench keeps a small set and tag pool so that sets fill up, ages reach saturation and equal ages force ties. A design that wrapped its counters instead of saturating them would then pick a recently used way as the victim. A design that broke ties toward the highest index would name the wrong miss_way. Fills are sometimes withheld, which leaves holes in a set. This catches a design that preferred an old valid way over a free one, or that issued a write-back while a free way still existed. Dirty lines are later evicted and checked against the stored tag, not the request tag. Replays mixed into the stream show whether a replay wrongly ages ways or raises a miss.

// File: rtl/tag_lookup_lru.sv
module tag_lookup_lru #(
  parameter int WAYS = 4,
  parameter int SETS = 4,
  parameter int TAG_W = 6,
  parameter int AGE_W = 2,
  parameter int REQ_N = 2,
  parameter int BANK_W = 1,
  parameter int BANK_ID = 1,
  parameter bit WRITE_THROUGH = 1'b0,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int ADDR_W = TAG_W + SET_W + BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_replay,
  input  logic              req_write,
  input  logic [SET_W-1:0]  req_set,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [REQ_N-1:0]  req_who,
  input  logic              fill_valid,
  input  logic [SET_W-1:0]  fill_set,
  input  logic [WAY_W-1:0]  fill_way,
  input  logic [TAG_W-1:0]  fill_tag,
  output logic              rsp_valid,
  output logic [REQ_N-1:0]  rsp_who,
  output logic              mem_wr_valid,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic              miss_valid,
  output logic              miss_write,
  output logic [WAY_W-1:0]  miss_way,
  output logic [ADDR_W-1:0] miss_addr
);
  localparam logic [AGE_W-1:0] AGE_MAX = '1;
  localparam logic [BANK_W-1:0] BANK = BANK_W'(BANK_ID);

  logic [WAYS-1:0]  vld_q [SETS];
  logic [WAYS-1:0]  dty_q [SETS];
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [AGE_W-1:0] age_q [SETS][WAYS];

  logic [AGE_W-1:0] age_nx [WAYS];
  logic [AGE_W-1:0] best;
  logic [WAYS-1:0]  match;
  logic             free;
  logic [WAY_W-1:0] vic;

  always_comb begin
    match = '0;
    free  = 1'b0;
    vic   = '0;
    best  = '0;
    for (int w = 0; w < WAYS; w++) begin
      age_nx[w] = age_q[req_set][w];
      if (vld_q[req_set][w]) begin
        if (tag_q[req_set][w] == req_tag) begin
          match[w]  = 1'b1;
          age_nx[w] = '0;
        end else if (age_q[req_set][w] != AGE_MAX) begin
          age_nx[w] = age_q[req_set][w] + 1'b1;
        end
      end
    end
    for (int w = WAYS - 1; w >= 0; w--)
      if (!vld_q[req_set][w]) begin
        free = 1'b1;
        vic  = WAY_W'(w);
      end
    if (!free)
      for (int w = 0; w < WAYS; w++)
        if (w == 0 || age_nx[w] > best) begin
          best = age_nx[w];
          vic  = WAY_W'(w);
        end
  end

  wire lookup = req_valid && !req_replay;
  wire hit    = lookup && (|match);
  wire miss   = lookup && !hit;
  wire wt_wr  = WRITE_THROUGH && req_write;

  assign rsp_valid    = req_valid && (req_replay || hit || (miss && wt_wr));
  assign rsp_who      = rsp_valid ? req_who : '0;
  assign mem_wr_valid = lookup && wt_wr;
  assign mem_wr_addr  = {req_tag, req_set, BANK};
  assign wb_valid     = miss && !WRITE_THROUGH && !free && dty_q[req_set][vic];
  assign wb_addr      = {tag_q[req_set][vic], req_set, BANK};
  assign miss_valid   = miss && !wt_wr;
  assign miss_write   = req_write;
  assign miss_way     = vic;
  assign miss_addr    = {req_tag, req_set, BANK};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        dty_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= '0;
      end
    end else begin
      if (lookup)
        for (int w = 0; w < WAYS; w++) begin
          age_q[req_set][w] <= age_nx[w];
          if (match[w] && req_write && !WRITE_THROUGH) dty_q[req_set][w] <= 1'b1;
        end
      if (fill_valid) begin
        vld_q[fill_set][fill_way] <= 1'b1;
        dty_q[fill_set][fill_way] <= 1'b0;
        age_q[fill_set][fill_way] <= '0;
      end
    end
  end

  always_ff @(posedge clk)
    if (rst_n && fill_valid) tag_q[fill_set][fill_way] <= fill_tag;

endmodule

// File: rtl/tag_lookup_lru_chk.sv
module tag_lookup_lru_chk #(
  parameter int SET_W = 2,
  parameter int TAG_W = 6,
  parameter bit WT = 1'b0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_replay,
  input logic             req_write,
  input logic [SET_W-1:0] req_set,
  input logic [TAG_W-1:0] req_tag,
  input logic             fill_valid,
  input logic [SET_W-1:0] fill_set,
  input logic [TAG_W-1:0] fill_tag,
  input logic             rsp_valid,
  input logic             mem_wr_valid,
  input logic             wb_valid,
  input logic             miss_valid
);
  AST_REPLAY_ONLY_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_replay |-> rsp_valid && !miss_valid && !wb_valid && !mem_wr_valid); // R1
  AST_RSP_MISS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_valid && miss_valid)); // R6
  AST_WB_ONLY_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> miss_valid && !rsp_valid && !WT); // R7
  AST_WT_WRITE_FORWARDS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_replay && req_write && WT |-> mem_wr_valid && rsp_valid && !miss_valid); // R8
  AST_FILL_THEN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(fill_valid) && req_valid && !req_replay
      && req_set == $past(fill_set) && req_tag == $past(fill_tag) |-> rsp_valid); // R10
endmodule

bind tag_lookup_lru tag_lookup_lru_chk #(.SET_W(SET_W), .TAG_W(TAG_W), .WT(WRITE_THROUGH)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_replay(req_replay),
  .req_write(req_write), .req_set(req_set), .req_tag(req_tag),
  .fill_valid(fill_valid), .fill_set(fill_set), .fill_tag(fill_tag),
  .rsp_valid(rsp_valid), .mem_wr_valid(mem_wr_valid), .wb_valid(wb_valid),
  .miss_valid(miss_valid)
);

// File: tb/tag_lookup_lru_bench.sv
module tag_lookup_lru_bench;
  localparam int CLK_P = 10;
  localparam int WAYS = 4, SETS = 4, TAG_W = 6, AGE_W = 2, REQ_N = 2;
  localparam int SET_W = 2, WAY_W = 2, ADDR_W = TAG_W + SET_W + 1;
  localparam int AMAX = (1 << AGE_W) - 1;

  logic clk = 0, rst_n = 0;
  always #(CLK_P/2) clk = ~clk;

  logic rv = 0, rr = 0, rw = 0;
  logic [SET_W-1:0] rs = 0;
  logic [TAG_W-1:0] rt = 0;
  logic [REQ_N-1:0] rwho = 0;
  logic fv [2];
  logic [SET_W-1:0] fs [2];
  logic [WAY_W-1:0] fw [2];
  logic [TAG_W-1:0] ft [2];

  logic o_rsp [2], o_mw [2], o_wb [2], o_miss [2], o_mwr [2];
  logic [REQ_N-1:0] o_who [2];
  logic [ADDR_W-1:0] o_mwa [2], o_wba [2], o_ma [2];
  logic [WAY_W-1:0] o_way [2];

  tag_lookup_lru #(.WRITE_THROUGH(1'b0)) u_tag_lookup_lru (
    .clk(clk), .rst_n(rst_n), .req_valid(rv), .req_replay(rr), .req_write(rw),
    .req_set(rs), .req_tag(rt), .req_who(rwho),
    .fill_valid(fv[0]), .fill_set(fs[0]), .fill_way(fw[0]), .fill_tag(ft[0]),
    .rsp_valid(o_rsp[0]), .rsp_who(o_who[0]), .mem_wr_valid(o_mw[0]), .mem_wr_addr(o_mwa[0]),
    .wb_valid(o_wb[0]), .wb_addr(o_wba[0]), .miss_valid(o_miss[0]), .miss_write(o_mwr[0]),
    .miss_way(o_way[0]), .miss_addr(o_ma[0]));

  tag_lookup_lru #(.WRITE_THROUGH(1'b1)) u_tag_lookup_lru_wt (
    .clk(clk), .rst_n(rst_n), .req_valid(rv), .req_replay(rr), .req_write(rw),
    .req_set(rs), .req_tag(rt), .req_who(rwho),
    .fill_valid(fv[1]), .fill_set(fs[1]), .fill_way(fw[1]), .fill_tag(ft[1]),
    .rsp_valid(o_rsp[1]), .rsp_who(o_who[1]), .mem_wr_valid(o_mw[1]), .mem_wr_addr(o_mwa[1]),
    .wb_valid(o_wb[1]), .wb_addr(o_wba[1]), .miss_valid(o_miss[1]), .miss_write(o_mwr[1]),
    .miss_way(o_way[1]), .miss_addr(o_ma[1]));

  int total = 0, bad = 0;
  bit m_vld [2][SETS][WAYS];
  bit m_dty [2][SETS][WAYS];
  logic [TAG_W-1:0] m_tag [2][SETS][WAYS];
  int m_age [2][SETS][WAYS];
  int e_age [2][WAYS];
  bit e_match [2][WAYS];
  bit pend [2];
  logic [SET_W-1:0] p_set [2];
  logic [WAY_W-1:0] p_way [2];
  logic [TAG_W-1:0] p_tag [2];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_inst(input int i, input bit first_touch);
    bit wt, lk, hit, free, e_rsp, e_mw, e_wb, e_miss;
    int vic, best;
    wt = (i == 1);
    lk = rv && !rr;
    hit = 0; free = 0; vic = 0; best = 0;
    for (int w = 0; w < WAYS; w++) begin
      e_match[i][w] = 0;
      e_age[i][w] = m_age[i][rs][w];
      if (m_vld[i][rs][w]) begin
        if (m_tag[i][rs][w] == rt) begin e_match[i][w] = 1; hit = lk; e_age[i][w] = 0; end
        else if (e_age[i][w] < AMAX) e_age[i][w]++;   // R2 saturating age
      end
    end
    for (int w = WAYS - 1; w >= 0; w--) if (!m_vld[i][rs][w]) begin free = 1; vic = w; end
    if (!free) for (int w = 0; w < WAYS; w++) if (w == 0 || e_age[i][w] > best) begin best = e_age[i][w]; vic = w; end
    e_rsp  = rv && (rr || hit || (lk && !hit && rw && wt));
    e_mw   = lk && rw && wt;
    e_wb   = lk && !hit && !wt && !free && m_dty[i][rs][vic];
    e_miss = lk && !hit && !(rw && wt);
    chk(rr ? "R1 rsp_valid" : (hit ? "R6 rsp_valid" : "R8 rsp_valid"), 32'(o_rsp[i]), 32'(e_rsp));
    chk("R6 rsp_who", 32'(o_who[i]), e_rsp ? 32'(rwho) : 0);
    chk(hit ? "R4 mem_wr_valid" : "R8 mem_wr_valid", 32'(o_mw[i]), 32'(e_mw));
    if (e_mw) chk("R9 mem_wr_addr", 32'(o_mwa[i]), 32'({rt, rs, 1'b1}));
    chk("R7,R5 wb_valid", 32'(o_wb[i]), 32'(e_wb));
    if (e_wb) chk("R7 wb_addr", 32'(o_wba[i]), 32'({m_tag[i][rs][vic], rs, 1'b1}));
    chk("R9 miss_valid", 32'(o_miss[i]), 32'(e_miss));
    if (e_miss) begin
      chk("R3,R2 miss_way", 32'(o_way[i]), 32'(vic));
      chk("R9 miss_addr", 32'(o_ma[i]), 32'({rt, rs, 1'b1}));
      chk("R9 miss_write", 32'(o_mwr[i]), 32'(rw));
    end
    if (first_touch)
      chk("R11 fresh set misses to way 0", 32'({o_miss[i], o_way[i], o_wb[i]}), 32'({1'b1, 2'd0, 1'b0}));
    // remember miss for a later fill (R10)
    if (e_miss) begin pend[i] = 1; p_set[i] = rs; p_way[i] = WAY_W'(vic); p_tag[i] = rt; end
  endtask

  task automatic update_inst(input int i);
    if (rv && !rr)
      for (int w = 0; w < WAYS; w++) begin
        m_age[i][rs][w] = e_age[i][w];
        if (e_match[i][w] && rw && i == 0) m_dty[i][rs][w] = 1;   // R5
      end
    if (fv[i]) begin   // R10 fill wins
      m_vld[i][fs[i]][fw[i]] = 1;
      m_dty[i][fs[i]][fw[i]] = 0;
      m_age[i][fs[i]][fw[i]] = 0;
      m_tag[i][fs[i]][fw[i]] = ft[i];
    end
  endtask

  task automatic step(input bit v, input bit rep, input bit wr, input int s, input int t,
                      input int who, input bit fill_ok, input bit first_touch);
    @(negedge clk);
    rv = v; rr = rep; rw = wr; rs = SET_W'(s); rt = TAG_W'(t); rwho = REQ_N'(who);
    for (int i = 0; i < 2; i++) begin
      fv[i] = pend[i] && fill_ok;
      fs[i] = p_set[i]; fw[i] = p_way[i]; ft[i] = p_tag[i];
      if (fv[i]) pend[i] = 0;
    end
    #2;
    for (int i = 0; i < 2; i++) check_inst(i, first_touch);
    @(posedge clk);
    #1;
    for (int i = 0; i < 2; i++) update_inst(i);
  endtask

  initial begin
    #(CLK_P * 200000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2; i++) begin
      fv[i] = 0; fs[i] = 0; fw[i] = 0; ft[i] = 0; pend[i] = 0; p_set[i] = 0; p_way[i] = 0; p_tag[i] = 0;
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          m_vld[i][s][w] = 0; m_dty[i][s][w] = 0; m_tag[i][s][w] = 0; m_age[i][s][w] = 0;
        end
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R11: each set read once right after reset, no fills delivered
    for (int s = 0; s < SETS; s++) step(1, 0, 0, s, 5, 1, 0, 1);
    for (int i = 0; i < 2; i++) pend[i] = 0;
    // R1: replay right after reset, nothing stored
    step(1, 1, 1, 2, 7, 3, 0, 0);
    // sweep: small tag pool forces full sets, saturation and ties
    for (int n = 0; n < 6000; n++) begin
      int r;
      r = $urandom;
      step((r & 7) != 0, ((r >> 3) & 7) == 0, (r >> 6) & 1, (r >> 7) & 3,
           (r >> 9) % 6, 1 + ((r >> 12) % 3), ((r >> 14) & 3) != 0, 0);
    end
    step(0, 0, 0, 0, 0, 0, 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule